// File: doc/BRIEF.md
# Processor Clock and Wait-Stretch Generator

This block turns one fast input clock into two half-rate clocks. The processor clock paces bus and instruction cycles, and each of its rising edges starts a new cycle. The timing clock has the same rate and phase, but it never stops, so counters and timers that run on it keep going while a slow device holds the bus.

A wait request can stretch the low phase of the processor clock by whole periods. The request is sampled once per period, at the input-clock edge where the processor clock would otherwise rise. The block also produces a one-input-clock cycle-start strobe, a wait-active flag, and a reset qualifier. The reset qualifier accepts the raw active-high reset request only after it has stayed high for a minimum run of input-clock edges.

Inside, a five-state phase machine drives the clocks. PH_IDLE is the reset state with both clocks low. PH_HIGH is the high half of a normal period and PH_LOW is its low half. PH_STR_HI and PH_STR_LO are the two halves of a stretched period: the timing clock is high or low in them and the processor clock stays low. The transitions are these:
- Any state goes to PH_IDLE while the qualified reset is active.
- PH_IDLE goes to PH_LOW.
- PH_HIGH goes to PH_LOW.
- PH_LOW goes to PH_STR_HI when wait is high and to PH_HIGH when it is low.
- PH_STR_HI goes to PH_STR_LO.
- PH_STR_LO goes to PH_STR_HI when wait is high and to PH_HIGH when it is low.

Top module: `pclk_stretch_gen`

## Requirements
- R1: Outside reset, from the second input-clock edge after the qualified reset drops, the timing clock inverts on every rising input-clock edge. Its period is therefore two input clocks.
- R2: The processor clock is high only in input-clock periods in which the timing clock is also high. In an unstretched period both rise on the same edge.
- R3: The wait input is sampled at the edge that ends a low half of the processor clock (PH_LOW or PH_STR_LO). If it is high there, the processor clock stays low for two more input clocks while the timing clock keeps toggling.
- R4: A wait that is still high at the next such edge stretches the cycle by a further full period. There is no limit on the number of stretches.
- R5: When wait is low at a sampling edge after a stretch, the processor clock rises on that edge, on the same edge as the timing clock.
- R6: The cycle-start output is high for exactly the input-clock period that follows each processor-clock rising edge. It is never high during a stretched period.
- R7: The wait-active output is high in both input-clock periods of every stretched period and low at all other times.
- R8: A reset request that is high for fewer than RST_HOLD (default 4) consecutive rising input-clock edges is ignored, and both clocks keep running undisturbed.
- R9: When the reset request has been high on RST_HOLD consecutive edges, all four outputs are low from the following edge. They stay low while the request remains high, and the wait input has no effect during that time.
- R10: After the reset request goes low, the processor clock first rises on the third rising input-clock edge. Wait is ignored at the first of these edges and sampled at the third.
- R11: A wait input that is high only at the edge ending a high half (PH_HIGH) has no effect, and the next rise follows two input clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_req | input | 1 | Raw reset request, active high |
| wait_i | input | 1 | Request to stretch the current processor cycle |
| pclk_o | output | 1 | Processor clock, half rate, stretchable low phase |
| tclk_o | output | 1 | Timing clock, half rate, free running |
| cyc_start_o | output | 1 | One-input-clock strobe after each processor-clock rise |
| wait_act_o | output | 1 | High while the processor clock is held low by wait |

## Verification
The assertions assume that wait_i and rst_req change only between rising input-clock edges and are stable at each edge, as signals from a synchronous source are. The bench drives every input on the falling edge and samples the outputs on the falling edge too, so each value is settled half a period before the edge that uses it. The properties on stretch entry and exit also assume that the qualified reset was inactive in the sampling cycle. The bench changes reset only at chosen points, when the machine is in PH_LOW.

// File: rtl/pclk_gen_pkg.sv
`timescale 1ns/1ps
package pclk_gen_pkg;

    // Phase of the divided clock pair
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_HIGH   = 3'd1,
        PH_LOW    = 3'd2,
        PH_STR_HI = 3'd3,
        PH_STR_LO = 3'd4
    } phase_e;

    // Registered output bundle
    typedef struct packed {
        logic pclk;
        logic tclk;
        logic cyc;
        logic wact;
    } clk_out_t;

endpackage

// File: rtl/pclk_rst_qual.sv
`timescale 1ns/1ps
module pclk_rst_qual #(
    parameter int RST_HOLD = 4
) (
    input  logic clk_in,
    input  logic rst_req,
    output logic rst_active
);
    localparam int CNT_W = (RST_HOLD > 2) ? $clog2(RST_HOLD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_HOLD - 1);

    logic [CNT_W-1:0] run_q;
    logic             act_q;

    // Count consecutive high samples and saturate at LAST.
    // Reset becomes active on the RST_HOLD-th consecutive high edge.
    always_ff @(posedge clk_in) begin
        if (!rst_req) begin
            run_q <= '0;
            act_q <= 1'b0;
        end else begin
            act_q <= (run_q == LAST);
            if (run_q != LAST) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign rst_active = act_q;

endmodule

// File: rtl/pclk_phase_fsm.sv
`timescale 1ns/1ps
module pclk_phase_fsm
    import pclk_gen_pkg::*;
(
    input  logic   clk_in,
    input  logic   rst_active,
    input  logic   wait_i,
    output phase_e st_nxt
);
    phase_e st_q;

    // State register
    always_ff @(posedge clk_in) begin
        st_q <= st_nxt;
    end

    // Next-state logic; wait only matters at the end of a low half
    always_comb begin
        st_nxt = st_q;
        if (rst_active) begin
            st_nxt = PH_IDLE;
        end else begin
            unique case (st_q)
                PH_IDLE:   st_nxt = PH_LOW;
                PH_HIGH:   st_nxt = PH_LOW;
                PH_LOW:    st_nxt = wait_i ? PH_STR_HI : PH_HIGH;
                PH_STR_HI: st_nxt = PH_STR_LO;
                PH_STR_LO: st_nxt = wait_i ? PH_STR_HI : PH_HIGH;
                default:   st_nxt = PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pclk_out_reg.sv
`timescale 1ns/1ps
module pclk_out_reg
    import pclk_gen_pkg::*;
(
    input  logic     clk_in,
    input  phase_e   st_nxt,
    output clk_out_t outs_q
);
    // Outputs are decoded from the next state and registered,
    // so each clock leaves a flop directly.
    always_ff @(posedge clk_in) begin
        unique case (st_nxt)
            PH_HIGH: begin
                outs_q.pclk <= 1'b1;
                outs_q.tclk <= 1'b1;
                outs_q.cyc  <= 1'b1;
                outs_q.wact <= 1'b0;
            end
            PH_STR_HI: begin
                outs_q.pclk <= 1'b0;
                outs_q.tclk <= 1'b1;
                outs_q.cyc  <= 1'b0;
                outs_q.wact <= 1'b1;
            end
            PH_STR_LO: begin
                outs_q.pclk <= 1'b0;
                outs_q.tclk <= 1'b0;
                outs_q.cyc  <= 1'b0;
                outs_q.wact <= 1'b1;
            end
            default: begin
                outs_q.pclk <= 1'b0;
                outs_q.tclk <= 1'b0;
                outs_q.cyc  <= 1'b0;
                outs_q.wact <= 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pclk_stretch_gen.sv
`timescale 1ns/1ps
module pclk_stretch_gen
    import pclk_gen_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic clk_in,
    input  logic rst_req,
    input  logic wait_i,
    output logic pclk_o,
    output logic tclk_o,
    output logic cyc_start_o,
    output logic wait_act_o
);
    logic     rst_active;
    phase_e   st_nxt;
    clk_out_t outs_q;

    pclk_rst_qual #(.RST_HOLD(RST_HOLD)) rst_qual_i (
        .clk_in     (clk_in),
        .rst_req    (rst_req),
        .rst_active (rst_active)
    );

    pclk_phase_fsm fsm_i (
        .clk_in     (clk_in),
        .rst_active (rst_active),
        .wait_i     (wait_i),
        .st_nxt     (st_nxt)
    );

    pclk_out_reg out_i (
        .clk_in (clk_in),
        .st_nxt (st_nxt),
        .outs_q (outs_q)
    );

    assign pclk_o      = outs_q.pclk;
    assign tclk_o      = outs_q.tclk;
    assign cyc_start_o = outs_q.cyc;
    assign wait_act_o  = outs_q.wact;

endmodule

// File: rtl/pclk_stretch_chk.sv
`timescale 1ns/1ps
module pclk_stretch_chk #(
    parameter int RST_HOLD = 4
) (
    input logic clk_in,
    input logic rst_req,
    input logic rst_active,
    input logic wait_i,
    input logic pclk_o,
    input logic tclk_o,
    input logic cyc_start_o,
    input logic wait_act_o
);
    localparam int RUN_W = $clog2(RST_HOLD + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RST_HOLD);

    logic [RUN_W-1:0] run_cnt = '0;

    always_ff @(posedge clk_in) begin
        if (!rst_req) begin
            run_cnt <= '0;
        end else if (run_cnt != RUN_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_TCLK_HALF_RATE: assert property (@(posedge clk_in) disable iff (rst_active) tclk_o |=> !tclk_o); // R1
    AST_PCLK_IN_TCLK:   assert property (@(posedge clk_in) disable iff (rst_active) pclk_o |-> tclk_o); // R2
    AST_WAIT_STRETCH:   assert property (@(posedge clk_in) disable iff (rst_active) (!tclk_o && $past(tclk_o) && wait_i) |=> (tclk_o && !pclk_o && wait_act_o)); // R3
    AST_STRETCH_EXIT:   assert property (@(posedge clk_in) disable iff (rst_active) ($fell(wait_act_o) && !$past(rst_active)) |-> (pclk_o && tclk_o)); // R5
    AST_START_NOT_WAIT: assert property (@(posedge clk_in) disable iff (rst_active) cyc_start_o |-> (pclk_o && !wait_act_o)); // R6
    AST_WAIT_LOW_PCLK:  assert property (@(posedge clk_in) disable iff (rst_active) wait_act_o |-> !pclk_o); // R7
    AST_RST_QUALIFIED:  assert property (@(posedge clk_in) disable iff (!rst_req) $rose(rst_active) |-> (run_cnt == RUN_MAX)); // R8
    AST_RST_QUIET:      assert property (@(posedge clk_in) disable iff (!rst_req) rst_active |=> (!pclk_o && !tclk_o && !cyc_start_o && !wait_act_o)); // R9

endmodule

bind pclk_stretch_gen pclk_stretch_chk #(.RST_HOLD(RST_HOLD)) chk_i (
    .clk_in      (clk_in),
    .rst_req     (rst_req),
    .rst_active  (rst_active),
    .wait_i      (wait_i),
    .pclk_o      (pclk_o),
    .tclk_o      (tclk_o),
    .cyc_start_o (cyc_start_o),
    .wait_act_o  (wait_act_o)
);

// File: tb/pclk_stretch_gen_tb_top.sv
`timescale 1ns/1ps
module pclk_stretch_gen_tb_top;

    logic clk_in = 1'b0;
    logic rst_req = 1'b1;
    logic wait_i = 1'b0;
    logic pclk_o, tclk_o, cyc_start_o, wait_act_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk_in = ~clk_in;

    pclk_stretch_gen #(.RST_HOLD(4)) dut_i (
        .clk_in      (clk_in),
        .rst_req     (rst_req),
        .wait_i      (wait_i),
        .pclk_o      (pclk_o),
        .tclk_o      (tclk_o),
        .cyc_start_o (cyc_start_o),
        .wait_act_o  (wait_act_o)
    );

    // Advance one input clock, then compare {pclk,tclk,cyc,wact}
    task automatic step_chk(input string req, input logic [3:0] exp);
        logic [3:0] got;
        @(posedge clk_in);
        @(negedge clk_in);
        got = {pclk_o, tclk_o, cyc_start_o, wait_act_o};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (pclk,tclk,cyc,wact) at %0t", req, got, exp, $time);
        end
    endtask

    localparam logic [3:0] O_HI  = 4'b1110;
    localparam logic [3:0] O_LO  = 4'b0000;
    localparam logic [3:0] O_SHI = 4'b0101;
    localparam logic [3:0] O_SLO = 4'b0001;

    // Full reset and release; leaves the machine in PH_LOW
    task automatic t_reset_release(input logic wait_at_first);
        rst_req = 1'b1;
        wait_i  = 1'b1;
        repeat (5) begin
            @(posedge clk_in);
            @(negedge clk_in);
        end
        step_chk("R9 held low", O_LO);
        step_chk("R9 wait ignored in reset", O_LO);
        rst_req = 1'b0;
        wait_i  = 1'b1;
        step_chk("R10 edge one", O_LO);
        step_chk("R10 edge two", O_LO);
        wait_i = wait_at_first;
        if (wait_at_first) begin
            step_chk("R10 R3 first decision stretched", O_SHI);
            wait_i = 1'b0;
            step_chk("R7 second half", O_SLO);
            step_chk("R5 rejoin", O_HI);
        end else begin
            step_chk("R10 first rise", O_HI);
        end
        step_chk("R1 low half", O_LO);
    endtask

    task automatic t_free_run();
        wait_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step_chk("R1 R2 R6 rise", O_HI);
            step_chk("R1 R2 fall", O_LO);
        end
    endtask

    task automatic t_single_stretch();
        wait_i = 1'b1;
        step_chk("R3 stretch high half", O_SHI);
        step_chk("R7 stretch low half", O_SLO);
        wait_i = 1'b0;
        step_chk("R5 R6 rise after stretch", O_HI);
        step_chk("R1 low", O_LO);
    endtask

    task automatic t_double_stretch();
        wait_i = 1'b1;
        step_chk("R4 first stretch", O_SHI);
        step_chk("R4 first stretch low", O_SLO);
        step_chk("R4 second stretch", O_SHI);
        wait_i = 1'b0;
        step_chk("R4 second stretch low", O_SLO);
        step_chk("R5 rejoin", O_HI);
        step_chk("R1 low", O_LO);
    endtask

    task automatic t_wait_in_high();
        wait_i = 1'b0;
        step_chk("R11 rise", O_HI);
        wait_i = 1'b1;
        step_chk("R11 wait at high end ignored", O_LO);
        wait_i = 1'b0;
        step_chk("R11 next rise on time", O_HI);
        step_chk("R11 low", O_LO);
    endtask

    task automatic t_short_reset();
        rst_req = 1'b1;
        step_chk("R8 short pulse e1", O_HI);
        step_chk("R8 short pulse e2", O_LO);
        step_chk("R8 short pulse e3", O_HI);
        rst_req = 1'b0;
        step_chk("R8 after pulse", O_LO);
        step_chk("R8 still running", O_HI);
        step_chk("R8 low", O_LO);
    endtask

    task automatic t_long_reset();
        rst_req = 1'b1;
        step_chk("R9 e1", O_HI);
        step_chk("R9 e2", O_LO);
        step_chk("R9 e3", O_HI);
        step_chk("R9 e4", O_LO);
        step_chk("R9 e5 forced low", O_LO);
        step_chk("R9 e6 forced low", O_LO);
        rst_req = 1'b0;
        step_chk("R10 release e1", O_LO);
        step_chk("R10 release e2", O_LO);
        step_chk("R10 release e3 rise", O_HI);
        step_chk("R1 low", O_LO);
    endtask

    initial begin
        repeat (20000) @(posedge clk_in);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk_in);
        t_reset_release(1'b0);
        t_free_run();
        t_single_stretch();
        t_double_stretch();
        t_wait_in_high();
        t_short_reset();
        t_long_reset();
        t_reset_release(1'b1);
        t_free_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule